// File: doc/BRIEF.md
# Multi-Type Interrupt Aggregator

This block gathers interrupt requests of three kinds into one active-low interrupt line for a host. Monitored status levels raise a request whenever any of them changes value. One-cycle event pulses (such as slips or buffer overruns) raise a request when they fire. Overflow pulses from external error counters raise a request when a counter wraps. The monitoring logic and the counters themselves sit outside the block and arrive as inputs.

Each source has a pending bit and an enable bit. A pending bit is only armed while its enable is 1. The interrupt line is low while any pending bit whose enable is also 1 is set. Enables never stop the status register from sampling its inputs, and they never stop counter values from passing through to the host. Each class is cleared in its own way. Status-change bits clear when the host reads the status register. Event bits clear when the host writes 1 to them. An overflow bit clears when the host reads the value of its counter. In every class, a new request that arrives in the same cycle as a clear wins over the clear.

The host reaches the block through a simple synchronous register port: address, write data, write strobe and read strobe. Read data is registered.

Top module: `irq_aggregator`

## Requirements
- R1: After reset `irq_no` is 1, `rdata_o` is 0, and all pending bits and all enables are 0.
- R2: Address 0 reads the status inputs as they were sampled at the previous clock edge, bit i for input i. This happens whatever the enables hold.
- R3: When status input i changes in either direction while status enable bit i is 1, bit i at address 1 becomes 1.
- R4: A read of address 0 clears every status-change pending bit. A change that is detected in the same cycle still leaves its bit set.
- R5: Event pulse i, with event enable bit i at 1, sets bit i at address 2. Writing address 2 clears each bit where the write data holds 1 and leaves the other bits alone. An event in the same cycle as its clear leaves the bit set.
- R6: Overflow pulse k, with overflow enable bit k at 1, sets bit k at address 3. A read of address 8+k returns counter value k and clears only bit k at address 3.
- R7: A source whose enable bit is 0 does not set its pending bit.
- R8: The enables can be written and read back at address 4 (status), address 5 (event) and address 6 (overflow), with bit i for source i.
- R9: `irq_no` is 0 in the cycle after any pending bit with its enable at 1 is set, and is 1 otherwise. Clearing an enable releases the line while the pending bit stays set.
- R10: Read data appears on `rdata_o` in the cycle after `rd_i` and holds until the next read. Unmapped addresses read as 0. Writes to addresses 0, 1 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_i | input | N_STAT | Monitored status levels |
| evt_i | input | N_EVT | One-cycle event pulses |
| cnt_ovf_i | input | N_CNT | One-cycle counter overflow pulses |
| cnt_val_i | input | N_CNT*CNT_W | Packed counter values, counter k in slice k |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| irq_no | output | 1 | Interrupt request, active low, registered |

## Verification
The assertions assume that the inputs are synchronous to the clock and free of X after reset, that `wr_i` and `rd_i` are never both high, and that event and overflow inputs are plain levels sampled at each edge, which a one-cycle pulse satisfies. The bench drives every input on the falling edge. It issues at most one strobe per cycle, so read and write never overlap. Its random phase draws the counter values and the status levels freely, because the block adds no rules of its own about their values.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int A_STAT     = 0;
  localparam int A_STAT_INT = 1;
  localparam int A_EVT_INT  = 2;
  localparam int A_CNT_INT  = 3;
  localparam int A_STAT_EN  = 4;
  localparam int A_EVT_EN   = 5;
  localparam int A_CNT_EN   = 6;
  localparam int A_CNT_BASE = 8;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] arm;
  assign arm = set_i & en_i;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | arm;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & en_i)) |=> ((pend_o & $past(set_i & en_i)) == $past(set_i & en_i))); // R5
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(set_i & en_i)) == '0)); // R7
  AST_HOLD_UNCLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_o) & ~$past(clr_i) & ~pend_o) == '0)); // R4
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_agg_pkg::*;
#(
  parameter int N_STAT = 4,
  parameter int N_EVT  = 6,
  parameter int N_CNT  = 3,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [N_STAT-1:0]      stat_q_i,
  input  logic [N_STAT-1:0]      stat_pend_i,
  input  logic [N_EVT-1:0]       evt_pend_i,
  input  logic [N_CNT-1:0]       cnt_pend_i,
  input  logic [N_STAT-1:0]      stat_en_i,
  input  logic [N_EVT-1:0]       evt_en_i,
  input  logic [N_CNT-1:0]       cnt_en_i,
  input  logic [N_CNT*CNT_W-1:0] cnt_val_i,
  output logic [DATA_W-1:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(A_STAT):     rdata_o[N_STAT-1:0] = stat_q_i;
      ADDR_W'(A_STAT_INT): rdata_o[N_STAT-1:0] = stat_pend_i;
      ADDR_W'(A_EVT_INT):  rdata_o[N_EVT-1:0]  = evt_pend_i;
      ADDR_W'(A_CNT_INT):  rdata_o[N_CNT-1:0]  = cnt_pend_i;
      ADDR_W'(A_STAT_EN):  rdata_o[N_STAT-1:0] = stat_en_i;
      ADDR_W'(A_EVT_EN):   rdata_o[N_EVT-1:0]  = evt_en_i;
      ADDR_W'(A_CNT_EN):   rdata_o[N_CNT-1:0]  = cnt_en_i;
      default: begin
        for (int k = 0; k < N_CNT; k++)
          if (addr_i == ADDR_W'(A_CNT_BASE + k))
            rdata_o[CNT_W-1:0] = cnt_val_i[k*CNT_W +: CNT_W];
      end
    endcase
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_STAT = 4,
  parameter int N_EVT  = 6,
  parameter int N_CNT  = 3,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_STAT-1:0]      stat_i,
  input  logic [N_EVT-1:0]       evt_i,
  input  logic [N_CNT-1:0]       cnt_ovf_i,
  input  logic [N_CNT*CNT_W-1:0] cnt_val_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   irq_no
);
  logic [N_STAT-1:0] stat_q, stat_chg, stat_clr, stat_pend, stat_en_q;
  logic [N_EVT-1:0]  evt_clr, evt_pend, evt_en_q;
  logic [N_CNT-1:0]  cnt_clr, cnt_pend, cnt_en_q;
  logic [DATA_W-1:0] rd_word;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign stat_chg     = stat_i ^ stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_en_q <= '0;
      evt_en_q  <= '0;
      cnt_en_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(A_STAT_EN)) stat_en_q <= wdata_i[N_STAT-1:0];
      if (addr_i == ADDR_W'(A_EVT_EN))  evt_en_q  <= wdata_i[N_EVT-1:0];
      if (addr_i == ADDR_W'(A_CNT_EN))  cnt_en_q  <= wdata_i[N_CNT-1:0];
    end
  end

  // class-specific clear rules
  assign stat_clr = {N_STAT{rd_i && addr_i == ADDR_W'(A_STAT)}};
  assign evt_clr  = (wr_i && addr_i == ADDR_W'(A_EVT_INT)) ? wdata_i[N_EVT-1:0] : '0;

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt_clr
    assign cnt_clr[k] = rd_i && (addr_i == ADDR_W'(A_CNT_BASE + k));

    AST_CNT_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_clr[k] && !(cnt_ovf_i[k] && cnt_en_q[k])) |=> !cnt_pend[k]); // R6
  end

  irq_latch_bank #(.W(N_STAT)) u_stat_bank (
    .clk_i, .rst_ni, .set_i(stat_chg), .en_i(stat_en_q), .clr_i(stat_clr), .pend_o(stat_pend));
  irq_latch_bank #(.W(N_EVT)) u_evt_bank (
    .clk_i, .rst_ni, .set_i(evt_i), .en_i(evt_en_q), .clr_i(evt_clr), .pend_o(evt_pend));
  irq_latch_bank #(.W(N_CNT)) u_cnt_bank (
    .clk_i, .rst_ni, .set_i(cnt_ovf_i), .en_i(cnt_en_q), .clr_i(cnt_clr), .pend_o(cnt_pend));

  irq_read_mux #(
    .N_STAT(N_STAT), .N_EVT(N_EVT), .N_CNT(N_CNT),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rmux (
    .addr_i,
    .stat_q_i(stat_q), .stat_pend_i(stat_pend), .evt_pend_i(evt_pend), .cnt_pend_i(cnt_pend),
    .stat_en_i(stat_en_q), .evt_en_i(evt_en_q), .cnt_en_i(cnt_en_q),
    .cnt_val_i, .rdata_o(rd_word));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      irq_no  <= 1'b1;
    end else begin
      if (rd_i) rdata_o <= rd_word;
      irq_no <= ~(|(stat_pend & stat_en_q) | |(evt_pend & evt_en_q) | |(cnt_pend & cnt_en_q));
    end
  end

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> ($past(stat_pend) != '0 || $past(evt_pend) != '0 || $past(cnt_pend) != '0)); // R9
  AST_STAT_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(A_STAT)) |=> ((stat_pend & ~$past(stat_chg & stat_en_q)) == '0)); // R4
  AST_EN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(stat_en_q) && $stable(evt_en_q) && $stable(cnt_en_q))); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R10
  AST_STAT_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_q == $past(stat_i))); // R2
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4, NE = 6, NC = 3, CW = 8, AW = 4, DW = 8;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] stat = '0;
  logic [NE-1:0] evt = '0;
  logic [NC-1:0] ovf = '0;
  logic [NC*CW-1:0] cval = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic wr = 0, rd = 0;
  logic [DW-1:0] rdata;
  logic irq_n;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator #(.N_STAT(NS), .N_EVT(NE), .N_CNT(NC), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .stat_i(stat), .evt_i(evt), .cnt_ovf_i(ovf), .cnt_val_i(cval),
    .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .irq_no(irq_n));

  // behavioural reference model
  int m_sq, m_sp, m_ep, m_cp, m_se, m_ee, m_ce, m_rd;
  bit m_irq_n;

  function automatic int m_read(int a);
    if (a == 0) return m_sq;
    if (a == 1) return m_sp;
    if (a == 2) return m_ep;
    if (a == 3) return m_cp;
    if (a == 4) return m_se;
    if (a == 5) return m_ee;
    if (a == 6) return m_ce;
    if (a >= 8 && a < 8 + NC) return int'(cval[(a-8)*CW +: CW]);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sq = 0; m_sp = 0; m_ep = 0; m_cp = 0;
      m_se = 0; m_ee = 0; m_ce = 0; m_rd = 0; m_irq_n = 1;
    end else begin
      int a, nsp, nep, ncp;
      a = int'(addr);
      m_irq_n = ((m_sp & m_se) == 0) && ((m_ep & m_ee) == 0) && ((m_cp & m_ce) == 0);
      if (rd) m_rd = m_read(a);
      nsp = (rd && a == 0) ? 0 : m_sp;
      nep = (wr && a == 2) ? (m_ep & ~int'(wdata)) : m_ep;
      ncp = m_cp;
      if (rd && a >= 8 && a < 8 + NC) ncp = ncp & ~(1 << (a - 8));
      nsp = nsp | ((int'(stat) ^ m_sq) & m_se);
      nep = nep | (int'(evt) & m_ee);
      ncp = ncp | (int'(ovf) & m_ce);
      m_sp = nsp; m_ep = nep; m_cp = ncp;
      if (wr && a == 4) m_se = int'(wdata) & ((1 << NS) - 1);
      if (wr && a == 5) m_ee = int'(wdata) & ((1 << NE) - 1);
      if (wr && a == 6) m_ce = int'(wdata) & ((1 << NC) - 1);
      m_sq = int'(stat);
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison with the model
  always @(negedge clk) if (rst_n && !done) begin
    cycles++;
    chk(irq_n == m_irq_n, "R9 irq_no vs model", int'(irq_n), int'(m_irq_n));
    chk(int'(rdata) == m_rd, "R10 rdata_o vs model", int'(rdata), m_rd);
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", cycles, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic rd_reg(int a, output int v);
    @(negedge clk); rd = 1; addr = AW'(a);
    @(negedge clk); rd = 0;
    v = int'(rdata);
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk); wr = 1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic pulse_evt(int v);
    @(negedge clk); evt = NE'(v);
    @(negedge clk); evt = '0;
  endtask

  task automatic pulse_ovf(int v);
    @(negedge clk); ovf = NC'(v);
    @(negedge clk); ovf = '0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    chk(irq_n == 1'b1, "R1 irq_no in reset", int'(irq_n), 1);
    rst_n = 1;
    @(negedge clk);
    chk(irq_n == 1'b1 && rdata == '0, "R1 outputs after reset", int'(irq_n), 1);
    rd_reg(4, v); chk(v == 0, "R1 status enable reset", v, 0);
    rd_reg(2, v); chk(v == 0, "R1 event pending reset", v, 0);

    wr_reg(4, 'hF); wr_reg(5, 'h3F); wr_reg(6, 'h7);
    rd_reg(5, v); chk(v == 'h3F, "R8 event enable readback", v, 'h3F);
    rd_reg(6, v); chk(v == 'h7, "R8 overflow enable readback", v, 'h7);

    // status change class
    @(negedge clk); stat = 4'b0101;
    repeat (2) @(negedge clk);
    chk(irq_n == 1'b0, "R9 irq on status change", int'(irq_n), 0);
    rd_reg(1, v); chk(v == 'h5, "R3 rising change", v, 'h5);
    rd_reg(0, v); chk(v == 'h5, "R2 status value", v, 'h5);
    rd_reg(1, v); chk(v == 0, "R4 read clears", v, 0);
    @(negedge clk); stat = 4'b0001;
    repeat (2) @(negedge clk);
    rd_reg(1, v); chk(v == 'h4, "R3 falling change", v, 'h4);
    rd_reg(0, v);
    @(negedge clk); stat = 4'b0011; rd = 1; addr = '0;
    @(negedge clk); rd = 0;
    rd_reg(1, v); chk(v == 'h2, "R4 change beats read clear", v, 'h2);
    rd_reg(0, v);

    // event class
    pulse_evt('h06);
    rd_reg(2, v); chk(v == 'h06, "R5 event set", v, 'h06);
    wr_reg(2, 'h02);
    rd_reg(2, v); chk(v == 'h04, "R5 write-one clear", v, 'h04);
    @(negedge clk); wr = 1; addr = AW'(2); wdata = 'h04; evt = 'h04;
    @(negedge clk); wr = 0; evt = '0;
    rd_reg(2, v); chk(v == 'h04, "R5 event beats clear", v, 'h04);
    wr_reg(2, 'h04);
    rd_reg(2, v); chk(v == 0, "R5 cleared", v, 0);

    // disabled sources
    wr_reg(5, 'h3E);
    pulse_evt('h01);
    rd_reg(2, v); chk(v == 0, "R7 disabled event", v, 0);
    wr_reg(4, 0);
    @(negedge clk); stat = 4'b1011;
    repeat (2) @(negedge clk);
    rd_reg(1, v); chk(v == 0, "R7 disabled status change", v, 0);
    rd_reg(0, v); chk(v == 'hB, "R2 status sampled while disabled", v, 'hB);

    // counter overflow class
    cval = {8'h33, 8'h22, 8'h11};
    pulse_ovf('h5);
    rd_reg(3, v); chk(v == 'h5, "R6 overflow set", v, 'h5);
    rd_reg(8, v); chk(v == 'h11, "R6 counter 0 value", v, 'h11);
    rd_reg(3, v); chk(v == 'h4, "R6 counter read clears own bit", v, 'h4);
    rd_reg(10, v); chk(v == 'h33, "R6 counter 2 value", v, 'h33);
    rd_reg(3, v); chk(v == 0, "R6 all cleared", v, 0);

    // enable masks the line
    pulse_evt('h08);
    @(negedge clk);
    chk(irq_n == 1'b0, "R9 irq on event", int'(irq_n), 0);
    wr_reg(5, 'h30);
    repeat (2) @(negedge clk);
    chk(irq_n == 1'b1, "R9 disable releases line", int'(irq_n), 1);
    rd_reg(2, v); chk(v == 'h08, "R9 pending kept when masked", v, 'h08);
    wr_reg(2, 'h08);

    // read-only and unmapped
    wr_reg(1, 'hFF); rd_reg(1, v); chk(v == 0, "R10 write to addr 1 ignored", v, 0);
    wr_reg(3, 'hFF); rd_reg(3, v); chk(v == 0, "R10 write to addr 3 ignored", v, 0);
    wr_reg(0, 'hFF); rd_reg(0, v); chk(v == 'hB, "R10 write to addr 0 ignored", v, 'hB);
    rd_reg(7, v); chk(v == 0, "R10 unmapped reads zero", v, 0);

    // random phase, compared with the model every clock
    wr_reg(4, 'hF); wr_reg(5, 'h3F); wr_reg(6, 'h7);
    for (int i = 0; i < 600; i++) begin
      int op;
      @(negedge clk);
      op = int'($urandom_range(0, 5));
      rd = 0; wr = 0;
      stat = ($urandom_range(0, 3) == 0) ? NS'($urandom) : stat;
      evt = ($urandom_range(0, 2) == 0) ? NE'($urandom) : '0;
      ovf = ($urandom_range(0, 3) == 0) ? NC'($urandom) : '0;
      cval = NC*CW'($urandom);
      addr = AW'($urandom_range(0, 11));
      wdata = DW'($urandom);
      if (op < 2) rd = 1;
      else if (op == 2) wr = 1;
    end
    @(negedge clk); rd = 0; wr = 0; evt = '0; ovf = '0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule